// File: doc/BRIEF.md
# Short-Frame PCM Serial Port

This block is the digital serial side of a single-channel voice codec. It runs on a fast system clock and treats the external bit clock, the transmit frame sync, the receive frame sync and the receive data line as asynchronous inputs. Each input passes through a two-flop synchronizer, and edges are found in the system-clock domain. In each frame one 8-bit companded sample goes out on a data pin with an output enable, which models an open-drain driver. One 8-bit sample comes in on the receive data pin. The transmit and receive directions are framed by separate short sync pulses.

Samples to send are written as parallel words into a holding register. A received sample is presented as a parallel word with a one-cycle valid strobe. An input selects A-law, which inverts the even-numbered bits of the character in both directions.

The block enters a power-save state when the bit clock stops toggling, or when the transmit sync stops arriving. It leaves that state at the next transmit sync. A separate active-low run input forces both directions idle. The system clock must run at least 8 times faster than the fastest bit clock, which is 2048 kHz.

Top module: `pcm_port`

## Requirements
- R1: Transmit sends the most significant bit first. The first bit appears after the first bit-clock rising edge that follows a transmit-sync rising edge, and each following rising edge presents the next bit.
- R2: Receive samples the data line on bit-clock falling edges, most significant bit first, starting at the first falling edge after a receive-sync rising edge.
- R3: The output enable is high only while the 8 transmit bits are driven. It turns on at the first bit-clock rise of the frame and turns off at the ninth.
- R4: When the law input is 1 (A-law), bits 6, 4, 2 and 0 of the word are inverted, which is an XOR with 0x55. This applies to the transmitted character and to the received word. When the law input is 0, words pass unchanged.
- R5: The transmit word is taken from a holding register at frame start. If no write happened since the previous frame, the old value is sent again and the underrun output pulses for one cycle.
- R6: If no bit-clock edge is seen for BCLK_STALL system clocks, the power-save output goes high and the output enable goes low.
- R7: If no transmit-sync rising edge is seen for SYNC_STALL system clocks, the power-save output goes high.
- R8: Power-save stays set until a transmit-sync rising edge arrives while the bit clock is running. Transmission of that frame then proceeds normally.
- R9: While the run input is 0, the output enable is low from the next cycle, no frame is transmitted and no received word is reported.
- R10: After reset, the output enable, the received-word valid strobe, the underrun output and the power-save output are all 0.
- R11: The received word output changes only in the cycle its valid strobe is high, and it holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit-clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| bclkIn | input | 1 | External serial bit clock (asynchronous) |
| txSyncIn | input | 1 | Transmit short frame sync (asynchronous) |
| rxSyncIn | input | 1 | Receive short frame sync (asynchronous) |
| rxDataIn | input | 1 | Serial receive data |
| runEn | input | 1 | 1 = normal operation, 0 = power-down |
| lawSel | input | 1 | 0 = mu-law, 1 = A-law (even-bit inversion) |
| txWord | input | WORD_BITS | Sample to transmit |
| txWrite | input | 1 | Loads txWord into the holding register |
| pcmOut | output | 1 | Serial transmit data |
| pcmOe | output | 1 | Drive enable for pcmOut; pin is high impedance when 0 |
| rxWord | output | WORD_BITS | Last received sample |
| rxValid | output | 1 | One-cycle strobe when rxWord is updated |
| underrun | output | 1 | One-cycle pulse when a frame resends a stale sample |
| saveMode | output | 1 | Power-save state is active |

## Verification
The assertions assume that the bit clock, when running, holds each level for several system clocks, so that every edge survives the synchronizer. They also assume that the run input is a plain level. The stall check measures idle time from the raw bit-clock pin and allows a few cycles of slack for the synchronizer and edge-detect registers.

The stimulus drives all inputs on the falling system-clock edge. The bit clock runs with 8-cycle half periods. Each sync rises in the middle of a bit-clock low phase and falls after the first falling bit-clock edge. Receive data changes only right after a bit-clock rise. As a result, every sampled level is stable for many system clocks.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic txLoad;   // frame start: load shifter, enable driver
    logic txShift;  // next transmit bit
    logic txStop;   // ninth rising edge: release driver
    logic rxShift;  // capture one receive bit
    logic rxDone;   // last receive bit captured
    logic abort;    // power-save or power-down
  } strobes_t;
endpackage

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS  = 8,
  parameter int BCLK_STALL = 64,
  parameter int SYNC_STALL = 4096
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bclkRaw,
  input  logic     txSyncRaw,
  input  logic     rxSyncRaw,
  input  logic     runEn,
  output strobes_t stb,
  output logic     saveMode
);
  localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int BW = $clog2(BCLK_STALL + 1);
  localparam int SW = $clog2(SYNC_STALL + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_BITS - 1);
  localparam logic [BW-1:0] BCLK_MAX = BW'(BCLK_STALL);
  localparam logic [SW-1:0] SYNC_MAX = SW'(SYNC_STALL);

  // [0],[1] synchronizer, [2] edge-detect delay
  logic [2:0] bclkPipe, txPipe, rxPipe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPipe <= '0;
      txPipe   <= '0;
      rxPipe   <= '0;
    end else begin
      bclkPipe <= {bclkPipe[1:0], bclkRaw};
      txPipe   <= {txPipe[1:0], txSyncRaw};
      rxPipe   <= {rxPipe[1:0], rxSyncRaw};
    end
  end

  logic bclkRise, bclkFall, txRise, rxRise;
  assign bclkRise = bclkPipe[1] & ~bclkPipe[2];
  assign bclkFall = ~bclkPipe[1] & bclkPipe[2];
  assign txRise   = txPipe[1] & ~txPipe[2];
  assign rxRise   = rxPipe[1] & ~rxPipe[2];

  logic [BW-1:0] bclkIdle;
  logic [SW-1:0] syncIdle;
  logic stallNow, active;
  assign stallNow = ((bclkIdle == BCLK_MAX) & ~(bclkRise | bclkFall))
                  | ((syncIdle == SYNC_MAX) & ~txRise);
  assign active   = runEn & ~saveMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkIdle <= '0;
      syncIdle <= '0;
      saveMode <= 1'b0;
    end else begin
      if (bclkRise | bclkFall)     bclkIdle <= '0;
      else if (bclkIdle != BCLK_MAX) bclkIdle <= bclkIdle + 1'b1;
      if (txRise)                  syncIdle <= '0;
      else if (syncIdle != SYNC_MAX) syncIdle <= syncIdle + 1'b1;
      if (stallNow)    saveMode <= 1'b1;
      else if (txRise) saveMode <= 1'b0;
    end
  end

  logic txArm, txBusy, rxArm, rxBusy;
  logic [CW-1:0] txCnt, rxCnt;

  always_comb begin
    stb         = '0;
    stb.abort   = ~active;
    stb.txLoad  = active & bclkRise & txArm;
    stb.txShift = active & bclkRise & ~txArm & txBusy & (txCnt != LAST_BIT);
    stb.txStop  = active & bclkRise & ~txArm & txBusy & (txCnt == LAST_BIT);
    stb.rxShift = active & bclkFall & (rxArm | rxBusy);
    stb.rxDone  = stb.rxShift & ~rxArm & (rxCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txArm  <= 1'b0;
      txBusy <= 1'b0;
      txCnt  <= '0;
      rxArm  <= 1'b0;
      rxBusy <= 1'b0;
      rxCnt  <= '0;
    end else begin
      // transmit framing
      if (runEn & txRise)   txArm <= 1'b1;
      else if (stb.abort)   txArm <= 1'b0;
      else if (stb.txLoad)  txArm <= 1'b0;
      if (stb.abort)        txBusy <= 1'b0;
      else if (stb.txLoad)  txBusy <= 1'b1;
      else if (stb.txStop)  txBusy <= 1'b0;
      if (stb.txLoad)       txCnt <= '0;
      else if (stb.txShift) txCnt <= txCnt + 1'b1;
      // receive framing
      if (runEn & rxRise)   rxArm <= 1'b1;
      else if (stb.abort)   rxArm <= 1'b0;
      else if (stb.rxShift) rxArm <= 1'b0;
      if (stb.abort)                 rxBusy <= 1'b0;
      else if (stb.rxShift & rxArm)  rxBusy <= 1'b1;
      else if (stb.rxDone)           rxBusy <= 1'b0;
      if (stb.rxShift & rxArm)       rxCnt <= CW'(1);
      else if (stb.rxShift)          rxCnt <= rxCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_port_dpath.sv
module pcm_port_dpath
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic                 lawSel,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 txWrite,
  input  logic                 rxDataRaw,
  output logic                 pcmOut,
  output logic                 pcmOe,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid,
  output logic                 underrun
);
  // Even-numbered bits, counted 1..WORD_BITS from the MSB
  function automatic logic [WORD_BITS-1:0] evenMask();
    logic [WORD_BITS-1:0] m;
    for (int i = 0; i < WORD_BITS; i++) m[i] = ((WORD_BITS - i) % 2) == 0;
    return m;
  endfunction
  localparam logic [WORD_BITS-1:0] EVEN_MASK = evenMask();

  logic [WORD_BITS-1:0] lawMask;
  assign lawMask = lawSel ? EVEN_MASK : '0;

  logic [WORD_BITS-1:0] holdReg, txShReg, rxShReg, rxNext;
  logic fresh;
  logic [1:0] rxPipe;
  assign rxNext = {rxShReg[WORD_BITS-2:0], rxPipe[1]};
  assign pcmOut = txShReg[WORD_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      fresh    <= 1'b0;
      underrun <= 1'b0;
      txShReg  <= '0;
      pcmOe    <= 1'b0;
      rxPipe   <= '0;
      rxShReg  <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      if (txWrite) begin
        holdReg <= txWord;
        fresh   <= 1'b1;
      end else if (stb.txLoad) begin
        fresh   <= 1'b0;
      end
      underrun <= stb.txLoad & ~fresh;
      if (stb.txLoad)       txShReg <= holdReg ^ lawMask;
      else if (stb.txShift) txShReg <= txShReg << 1;
      if (stb.abort | stb.txStop) pcmOe <= 1'b0;
      else if (stb.txLoad)        pcmOe <= 1'b1;
      rxPipe <= {rxPipe[0], rxDataRaw};
      if (stb.rxShift) rxShReg <= rxNext;
      if (stb.rxDone)  rxWord  <= rxNext ^ lawMask;
      rxValid <= stb.rxDone;
    end
  end
endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_BITS  = 8,
  parameter int BCLK_STALL = 64,
  parameter int SYNC_STALL = 4096
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bclkIn,
  input  logic                 txSyncIn,
  input  logic                 rxSyncIn,
  input  logic                 rxDataIn,
  input  logic                 runEn,
  input  logic                 lawSel,
  input  logic [WORD_BITS-1:0] txWord,
  input  logic                 txWrite,
  output logic                 pcmOut,
  output logic                 pcmOe,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid,
  output logic                 underrun,
  output logic                 saveMode
);
  strobes_t stb;

  pcm_port_ctrl #(
    .WORD_BITS(WORD_BITS), .BCLK_STALL(BCLK_STALL), .SYNC_STALL(SYNC_STALL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkRaw(bclkIn), .txSyncRaw(txSyncIn),
    .rxSyncRaw(rxSyncIn), .runEn(runEn), .stb(stb), .saveMode(saveMode)
  );

  pcm_port_dpath #(.WORD_BITS(WORD_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .lawSel(lawSel), .txWord(txWord),
    .txWrite(txWrite), .rxDataRaw(rxDataIn), .pcmOut(pcmOut), .pcmOe(pcmOe),
    .rxWord(rxWord), .rxValid(rxValid), .underrun(underrun)
  );
endmodule

// File: rtl/pcm_port_chk.sv
module pcm_port_chk #(
  parameter int WORD_BITS  = 8,
  parameter int BCLK_STALL = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bclkIn,
  input logic                 runEn,
  input logic                 pcmOe,
  input logic [WORD_BITS-1:0] rxWord,
  input logic                 rxValid,
  input logic                 underrun,
  input logic                 saveMode
);
  localparam int LIMIT = BCLK_STALL + 6;
  localparam int IW    = $clog2(LIMIT + 2) + 1;

  // cycles since the raw bit clock last changed
  logic [IW-1:0] rawIdle;
  logic bclkPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawIdle  <= '0;
      bclkPrev <= 1'b0;
    end else begin
      bclkPrev <= bclkIn;
      if (bclkIn != bclkPrev)        rawIdle <= '0;
      else if (rawIdle <= IW'(LIMIT)) rawIdle <= rawIdle + 1'b1;
    end
  end

  assert_stall_save_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rawIdle > IW'(LIMIT)) |-> saveMode);
  assert_save_no_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    saveMode |=> !pcmOe);
  assert_down_no_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !pcmOe);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_underrun_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
  assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));
endmodule

bind pcm_port pcm_port_chk #(.WORD_BITS(WORD_BITS), .BCLK_STALL(BCLK_STALL)) u_chk (
  .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .runEn(runEn), .pcmOe(pcmOe),
  .rxWord(rxWord), .rxValid(rxValid), .underrun(underrun), .saveMode(saveMode)
);

// File: tb/pcm_port_bench.sv
module pcm_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BCLK_STALL = 64;
  localparam int SYNC_STALL = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bclkIn = 1'b0, txSyncIn = 1'b0, rxSyncIn = 1'b0, rxDataIn = 1'b0;
  logic runEn = 1'b1, lawSel = 1'b0, txWrite = 1'b0;
  logic [7:0] txWord = '0;
  logic pcmOut, pcmOe, rxValid, underrun, saveMode;
  logic [7:0] rxWord;

  int total = 0, bad = 0;
  int rxCount = 0, urCount = 0, oeCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_port #(.WORD_BITS(8), .BCLK_STALL(BCLK_STALL), .SYNC_STALL(SYNC_STALL)) u_pcm_port (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .txSyncIn(txSyncIn), .rxSyncIn(rxSyncIn),
    .rxDataIn(rxDataIn), .runEn(runEn), .lawSel(lawSel), .txWord(txWord),
    .txWrite(txWrite), .pcmOut(pcmOut), .pcmOe(pcmOe), .rxWord(rxWord),
    .rxValid(rxValid), .underrun(underrun), .saveMode(saveMode)
  );

  always @(posedge clk) begin
    if (rxValid)  rxCount++;
    if (underrun) urCount++;
    if (pcmOe)    oeCount++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input logic [7:0] w);
    @(negedge clk); txWord = w; txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      bclkIn = 1'b1; repeat (8) @(negedge clk);
      bclkIn = 1'b0; repeat (8) @(negedge clk);
    end
  endtask

  // One frame: syncs rise mid low phase, 8 data periods plus 2 trailing
  task automatic runFrame(input logic [7:0] rxByte, output logic [7:0] txGot,
                          output bit oeErr);
    oeErr = 1'b0; txGot = '0;
    repeat (4) @(negedge clk);
    if (pcmOe) oeErr = 1'b1;
    txSyncIn = 1'b1; rxSyncIn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      bclkIn = 1'b1;
      if (i < 8) rxDataIn = rxByte[7-i];
      repeat (7) @(negedge clk);
      if (i < 8) begin
        txGot[7-i] = pcmOut;
        if (!pcmOe) oeErr = 1'b1;
      end else if (pcmOe) oeErr = 1'b1;
      @(negedge clk); bclkIn = 1'b0;
      repeat (4) @(negedge clk);
      if (i == 0) begin txSyncIn = 1'b0; rxSyncIn = 1'b0; end
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset;
    check(pcmOe == 1'b0, "R10 oe", pcmOe, 0);
    check(rxValid == 1'b0, "R10 rxValid", rxValid, 0);
    check(underrun == 1'b0, "R10 underrun", underrun, 0);
    check(saveMode == 1'b0, "R10 saveMode", saveMode, 0);
  endtask

  task automatic test_mulaw;
    logic [7:0] got; bit oeErr; int rx0, ur0;
    lawSel = 1'b0; rx0 = rxCount; ur0 = urCount;
    writeWord(8'hA3);
    runFrame(8'h5C, got, oeErr);
    check(got == 8'hA3, "R1 tx msb first", got, 8'hA3);
    check(!oeErr, "R3 oe window", oeErr, 0);
    check(rxWord == 8'h5C, "R2 rx word", rxWord, 8'h5C);
    check(rxCount == rx0 + 1, "R2 one valid", rxCount - rx0, 1);
    check(urCount == ur0, "R5 no underrun when fresh", urCount - ur0, 0);
    idle(2);
    writeWord(8'h01);
    runFrame(8'h80, got, oeErr);
    check(got == 8'h01, "R1 tx pattern2", got, 8'h01);
    check(!oeErr, "R3 oe window 2", oeErr, 0);
    check(rxWord == 8'h80, "R2 rx pattern2", rxWord, 8'h80);
    idle(2);
  endtask

  task automatic test_alaw;
    logic [7:0] got; bit oeErr;
    lawSel = 1'b1;
    writeWord(8'hA3);
    runFrame(8'h5C, got, oeErr);
    check(got == 8'hF6, "R4 tx even-bit invert", got, 8'hF6);
    check(rxWord == 8'h09, "R4 rx even-bit invert", rxWord, 8'h09);
    idle(2);
  endtask

  task automatic test_underrun;
    logic [7:0] got; bit oeErr; int ur0;
    ur0 = urCount;
    runFrame(8'h00, got, oeErr);
    check(got == 8'hF6, "R5 stale resent", got, 8'hF6);
    check(urCount == ur0 + 1, "R5 underrun pulse", urCount - ur0, 1);
    idle(2);
  endtask

  task automatic test_bclk_stall;
    logic [7:0] got; bit oeErr;
    repeat (BCLK_STALL + 20) @(negedge clk);
    check(saveMode == 1'b1, "R6 bclk stall save", saveMode, 1);
    check(pcmOe == 1'b0, "R6 no drive in save", pcmOe, 0);
    idle(2);
    check(saveMode == 1'b1, "R8 held until sync", saveMode, 1);
    lawSel = 1'b0;
    writeWord(8'h3C);
    runFrame(8'hC3, got, oeErr);
    check(saveMode == 1'b0, "R8 resume at sync", saveMode, 0);
    check(got == 8'h3C, "R8 frame after resume", got, 8'h3C);
    check(rxWord == 8'hC3, "R8 rx after resume", rxWord, 8'hC3);
    idle(2);
  endtask

  task automatic test_sync_stall;
    logic [7:0] got; bit oeErr;
    idle(SYNC_STALL / 16 + 16);
    check(saveMode == 1'b1, "R7 sync stall save", saveMode, 1);
    writeWord(8'h7E);
    runFrame(8'h11, got, oeErr);
    check(saveMode == 1'b0, "R7 R8 resume", saveMode, 0);
    check(got == 8'h7E, "R7 frame after resume", got, 8'h7E);
    idle(2);
  endtask

  task automatic test_powerdown;
    logic [7:0] got; bit oeErr; int rx0, oe0, ur0;
    @(negedge clk); runEn = 1'b0;
    rx0 = rxCount; oe0 = oeCount;
    writeWord(8'h55);
    runFrame(8'hAA, got, oeErr);
    check(oeCount == oe0, "R9 no drive in power-down", oeCount - oe0, 0);
    check(rxCount == rx0, "R9 no rx in power-down", rxCount - rx0, 0);
    check(rxWord == 8'h11, "R11 rxWord held", rxWord, 8'h11);
    @(negedge clk); runEn = 1'b1;
    idle(2);
    ur0 = urCount;
    runFrame(8'h42, got, oeErr);
    check(got == 8'h55, "R9 frame after power-up", got, 8'h55);
    check(urCount == ur0, "R5 write kept across power-down", urCount - ur0, 0);
    check(rxWord == 8'h42, "R9 rx after power-up", rxWord, 8'h42);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_mulaw();
    test_alaw();
    test_underrun();
    test_bclk_stall();
    test_sync_stall();
    test_powerdown();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule